// File: doc/BRIEF.md
# Multi-Mode Reload Timer / Event Counter

This block is one 16-bit counter channel with a reload register and three run modes. In interval mode it counts down on an internal tick strobe and reloads itself whenever it wraps, so it divides the tick rate. In event mode it counts pulses instead. These come either from an external event strobe or from a chained strobe that another timer raises when it wraps, and the count can run up or down. In single-shot mode a rising start bit arms the channel. It then counts a programmed number of ticks, raises one interrupt and halts.

A reload value of zero inhibits the channel. The counter does not move, no interrupt is raised and the output pin does not toggle. Each wrap produces a one-cycle interrupt strobe. When pulse output is enabled, each wrap also toggles the output pin. The reload register is always written as a full word.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous reset `count`, `irq` and `tmr_out` are 0, and the reload value is 0.
- R2: While `start` is 0 the count does not change on any strobe and `irq` stays 0, except for a reload write (see R7).
- R3: The `mode` encodings are 0 for interval, 1 for event and 2 for single-shot. In interval mode (`mode`=0) with reload value n≥1, each cycle with `tick_in`=1 decrements `count`. The strobe that finds `count`=0 reloads n instead, so `irq` fires once every n+1 tick strobes. Cycles with `tick_in`=0 hold the count.
- R4: In event mode (`mode`=1) only the selected event strobe counts: `evt_ext` when `evt_sel`=0, `evt_chain` when `evt_sel`=1. `tick_in` is ignored. With `up_sel`=0 the channel counts down and wraps every n+1 events. With `up_sel`=1 it counts up and wraps every FFFFh−n+1 events, reloading n after FFFFh. `up_sel` has no effect in the other modes.
- R5: In single-shot mode (`mode`=2) a 0→1 change of `start` loads n without counting in that cycle. The n-th following tick strobe raises `irq` and reloads n. The channel then ignores ticks until `start` goes 0 and back to 1.
- R6: With reload value 0 the count never changes on strobes, `irq` stays 0 and `tmr_out` does not toggle.
- R7: A reload write made while the channel is stopped (`start`=0, or single-shot finished) also loads `count` with the written word on the next cycle.
- R8: A reload write while running leaves `count` on its path. The new value is loaded at the next wrap. A write in the same cycle as a wrap leaves that wrap loading the old value, and the new one is used at the wrap after.
- R9: With `pulse_en`=1, `tmr_out` toggles on every wrap. With `pulse_en`=0 it is driven low from the next cycle on.
- R10: `irq` is registered. It is high for the single cycle after the wrapping strobe, which is the same cycle in which `count` shows the reloaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Reload word write strobe |
| wr_data | input | 16 | Reload word |
| start | input | 1 | Run enable; its rising edge triggers single-shot |
| up_sel | input | 1 | Event mode direction: 0 down, 1 up |
| mode | input | 2 | 0 interval, 1 event, 2 single-shot |
| evt_sel | input | 1 | Event source: 0 external, 1 chained |
| pulse_en | input | 1 | Enable output toggling on wrap |
| tick_in | input | 1 | Internal count source strobe |
| evt_ext | input | 1 | External event strobe |
| evt_chain | input | 1 | Wrap strobe from a neighbouring timer |
| count | output | 16 | Current counter value |
| tmr_out | output | 1 | Pulse/toggle output |
| irq | output | 1 | Interrupt strobe, one cycle per wrap |

## Verification
The coincidence that matters is a reload write landing in the same cycle as a wrap. The bench first lets the counter reach zero, then drives the write word together with the final tick strobe. The check passes only if that wrap loads the previous reload value and the following wrap loads the newly written one. Each step of this sequence is also checked for the `irq` strobe and the output toggle.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  typedef enum logic [1:0] {
    RM_INTERVAL = 2'd0,
    RM_EVENT    = 2'd1,
    RM_ONESHOT  = 2'd2,
    RM_RSVD     = 2'd3
  } run_mode_e;
endpackage

// File: rtl/rt_reload.sv
module rt_reload #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rld_q,
  output logic         rld_zero
);
  // Whole-word reload store; zero flag kept registered to keep it off the count path.
  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q    <= '0;
      rld_zero <= 1'b1;
    end else if (wr_en) begin
      rld_q    <= wr_data;
      rld_zero <= (wr_data == '0);
    end
  end
endmodule

// File: rtl/rt_step_sel.sv
module rt_step_sel
  import rtimer_pkg::*;
(
  input  run_mode_e md,
  input  logic      tick_in,
  input  logic      evt_ext,
  input  logic      evt_chain,
  input  logic      evt_sel,
  output logic      step_raw
);
  always_comb begin
    unique case (md)
      RM_INTERVAL, RM_ONESHOT: step_raw = tick_in;
      RM_EVENT:                step_raw = evt_sel ? evt_chain : evt_ext;
      default:                 step_raw = 1'b0;
    endcase
  end
endmodule

// File: rtl/rt_core.sv
module rt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_now,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         dir_up,
  input  logic         oneshot,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic at_lim;

  // Single-shot finishes on the n-th tick, so its limit sits one above zero.
  always_comb begin
    if (dir_up)       at_lim = (cnt == MAXV);
    else if (oneshot) at_lim = (cnt == ONE);
    else              at_lim = (cnt == '0);
  end

  assign wrap = step & at_lim;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load_now) cnt <= load_val;
    else if (wrap)     cnt <= rld;
    else if (step)     cnt <= dir_up ? cnt + ONE : cnt - ONE;
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         up_sel,
  input  logic [1:0]   mode,
  input  logic         evt_sel,
  input  logic         pulse_en,
  input  logic         tick_in,
  input  logic         evt_ext,
  input  logic         evt_chain,
  output logic [W-1:0] count,
  output logic         tmr_out,
  output logic         irq
);
  run_mode_e md;
  logic [W-1:0] rld_q;
  logic [W-1:0] load_val;
  logic rld_zero, start_q, done_q;
  logic is_event, is_oneshot, trig, idle, active;
  logic step_raw, step, load_now, dir_up, wrap;

  assign md         = run_mode_e'(mode);
  assign is_event   = (md == RM_EVENT);
  assign is_oneshot = (md == RM_ONESHOT);
  assign trig       = is_oneshot & start & ~start_q;
  assign idle       = ~start | (is_oneshot & done_q);
  assign active     = start & ~rld_zero & ~(is_oneshot & done_q) & ~trig;
  assign step       = active & step_raw;
  assign load_now   = trig | (wr_en & idle);
  assign load_val   = wr_en ? wr_data : rld_q;
  assign dir_up     = is_event & up_sel;

  rt_reload #(.W(W)) u_reload (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rld_q(rld_q), .rld_zero(rld_zero)
  );

  rt_step_sel u_sel (
    .md(md), .tick_in(tick_in), .evt_ext(evt_ext), .evt_chain(evt_chain),
    .evt_sel(evt_sel), .step_raw(step_raw)
  );

  rt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load_now(load_now), .load_val(load_val),
    .step(step), .dir_up(dir_up), .oneshot(is_oneshot), .rld(rld_q),
    .cnt(count), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      tmr_out <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      irq     <= wrap;
      start_q <= start;
      if (!pulse_en) tmr_out <= 1'b0;
      else if (wrap) tmr_out <= ~tmr_out;
      if (trig)                   done_q <= 1'b0;
      else if (wrap & is_oneshot) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         pulse_en,
  input logic [1:0]   mode,
  input logic [W-1:0] count,
  input logic         irq,
  input logic         tmr_out,
  input logic [W-1:0] rld_q,
  input logic         rld_zero
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!start && !wr_en) |=> ($stable(count) && !irq));

  p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (rst)
    (irq && start && mode == 2'd2 && $past(mode) == 2'd2) |=> !irq);

  p_zero_no_irq_r6: assert property (@(posedge clk) disable iff (rst)
    rld_zero |=> !irq);

  p_zero_no_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (rld_zero && pulse_en) |=> $stable(tmr_out));

  p_stopped_load_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !start) |=> (count == $past(wr_data)));

  p_wrap_old_reload_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (count == $past(rld_q)));

  p_toggle_on_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(pulse_en)) |-> (tmr_out != $past(tmr_out)));

  p_out_low_r9: assert property (@(posedge clk) disable iff (rst)
    !pulse_en |=> !tmr_out);
endmodule

bind reload_timer rt_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_data(wr_data),
  .pulse_en(pulse_en), .mode(mode), .count(count), .irq(irq),
  .tmr_out(tmr_out), .rld_q(rld_q), .rld_zero(rld_zero)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0, up_sel = 1'b0, evt_sel = 1'b0, pulse_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        tick_in = 1'b0, evt_ext = 1'b0, evt_chain = 1'b0;
  logic [15:0] count;
  logic        tmr_out, irq;

  typedef struct {
    string       tag;
    logic [15:0] cnt;
    logic        irq;
    logic        out;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .start(start),
    .up_sel(up_sel), .mode(mode), .evt_sel(evt_sel), .pulse_en(pulse_en),
    .tick_in(tick_in), .evt_ext(evt_ext), .evt_chain(evt_chain),
    .count(count), .tmr_out(tmr_out), .irq(irq)
  );

  // Monitor: compares queued expectations just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (count !== e.cnt || irq !== e.irq || tmr_out !== e.out) begin
          n_bad++;
          $display("FAIL %s: count=%h irq=%b out=%b expected count=%h irq=%b out=%b",
                   e.tag, count, irq, tmr_out, e.cnt, e.irq, e.out);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_st(string tag, logic [15:0] c, logic i, logic o);
    exp_t e;
    e.tag = tag; e.cnt = c; e.irq = i; e.out = o;
    q.push_back(e);
  endtask

  task automatic write_word(logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;
    expect_st("R1 reset state", 16'h0000, 1'b0, 1'b0);

    // R7: write while stopped loads the counter
    write_word(16'd5);
    expect_st("R7 stopped write", 16'd5, 1'b0, 1'b0);

    // R2: strobes ignored while start is 0
    tick_in = 1'b1;
    for (int k = 0; k < 3; k++) tick();
    expect_st("R2 stopped hold", 16'd5, 1'b0, 1'b0);
    tick_in = 1'b0;

    // R3/R9/R10: interval mode, n = 3, period 4
    mode = 2'd0;
    write_word(16'd3);
    expect_st("R7 stopped write n3", 16'd3, 1'b0, 1'b0);
    start = 1'b1; pulse_en = 1'b1; tick_in = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      expect_st("R3 R9 R10 interval", 16'((3 - (k % 4) + 4) % 4),
                (k % 4) == 0, ((k / 4) % 2) == 1);
    end
    for (int j = 0; j < 6; j++) begin
      tick_in = (j % 2) == 0;
      tick();
      expect_st("R3 gated tick", 16'(2 - j / 2), 1'b0, 1'b0);
    end
    start = 1'b0; tick_in = 1'b0;
    pulse_en = 1'b0;
    tick();
    expect_st("R9 out low when disabled", 16'd0, 1'b0, 1'b0);

    // R4: event mode, down, external source, n = 2
    mode = 2'd1; up_sel = 1'b0; evt_sel = 1'b0;
    write_word(16'd2);
    expect_st("R7 stopped write n2", 16'd2, 1'b0, 1'b0);
    start = 1'b1; tick_in = 1'b1;
    tick();
    expect_st("R4 tick ignored in event mode", 16'd2, 1'b0, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      evt_ext = 1'b1;
      tick();
      expect_st("R4 event down", 16'((2 - (k % 3) + 3) % 3), (k % 3) == 0, 1'b0);
    end
    start = 1'b0; evt_ext = 1'b0; tick_in = 1'b0;

    // R4: event mode, up, chained source, n = FFFD, period 3
    up_sel = 1'b1; evt_sel = 1'b1;
    write_word(16'hFFFD);
    expect_st("R7 stopped write FFFD", 16'hFFFD, 1'b0, 1'b0);
    start = 1'b1; evt_ext = 1'b1;
    tick();
    expect_st("R4 unselected source ignored", 16'hFFFD, 1'b0, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      evt_chain = 1'b1;
      tick();
      expect_st("R4 event up", 16'hFFFD + 16'(k % 3), (k % 3) == 0, 1'b0);
    end
    start = 1'b0; evt_ext = 1'b0; evt_chain = 1'b0;

    // R5: single-shot, n = 3, up_sel left at 1 (must not matter)
    mode = 2'd2;
    write_word(16'd3);
    expect_st("R7 stopped write oneshot", 16'd3, 1'b0, 1'b0);
    tick_in = 1'b1; start = 1'b1;
    tick();
    expect_st("R5 trigger loads", 16'd3, 1'b0, 1'b0);
    tick(); expect_st("R5 shot tick1", 16'd2, 1'b0, 1'b0);
    tick(); expect_st("R5 shot tick2", 16'd1, 1'b0, 1'b0);
    tick(); expect_st("R5 shot end", 16'd3, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick();
      expect_st("R5 halted after shot", 16'd3, 1'b0, 1'b0);
    end
    start = 1'b0;
    tick();
    start = 1'b1;
    tick(); expect_st("R5 retrigger", 16'd3, 1'b0, 1'b0);
    tick(); expect_st("R5 second shot tick1", 16'd2, 1'b0, 1'b0);
    tick(); expect_st("R5 second shot tick2", 16'd1, 1'b0, 1'b0);
    tick(); expect_st("R5 second shot end", 16'd3, 1'b1, 1'b0);
    start = 1'b0; tick_in = 1'b0; up_sel = 1'b0;

    // R6: zero reload inhibits everything
    mode = 2'd0;
    write_word(16'd0);
    expect_st("R7 stopped write zero", 16'd0, 1'b0, 1'b0);
    pulse_en = 1'b1; tick_in = 1'b1; start = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      expect_st("R6 zero inhibit", 16'd0, 1'b0, 1'b0);
    end
    start = 1'b0; tick_in = 1'b0;

    // R8: running writes, including one coinciding with a wrap
    write_word(16'd2);
    expect_st("R7 stopped write n2b", 16'd2, 1'b0, 1'b0);
    start = 1'b1; tick_in = 1'b1;
    tick(); expect_st("R8 run", 16'd1, 1'b0, 1'b0);
    write_word(16'd5);
    expect_st("R8 running write not loaded", 16'd0, 1'b0, 1'b0);
    tick(); expect_st("R8 new value at wrap", 16'd5, 1'b1, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      tick();
      expect_st("R8 count down", 16'(5 - k), 1'b0, 1'b1);
    end
    write_word(16'd7);
    expect_st("R8 write on wrap uses old", 16'd5, 1'b1, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      tick();
      expect_st("R8 count down 2", 16'(5 - k), 1'b0, 1'b0);
    end
    tick(); expect_st("R8 later wrap uses new", 16'd7, 1'b1, 1'b1);
    start = 1'b0; tick_in = 1'b0;

    tick();
    tick();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule